// File: doc/BRIEF.md
# Filter Input Buffer Request Logic

This block drives the request lines and the overrun status for the one-word input buffer of a sample-processing filter. In host-feed mode a processor or DMA engine supplies samples. The block then raises a feed request whenever the buffer is empty and drops it as soon as a word is written in. In converter-feed mode an external converter loads samples into the buffer. If DMA and the debug monitor are both enabled, each loaded sample raises a monitor request so that DMA can copy the sample out.

A monitor overrun happens when a new converter sample lands while the previous monitor request is still pending. It sets a sticky flag. Software clears the flag with a write-one-to-clear strobe, but a simultaneous overrun wins over that clear. A soft reset returns both request lines, the buffer occupancy and the flag to idle. The interrupt output is the flag gated by its enable.

The block has no data path, so every pin is a plain control or status level. Strobes are single-cycle, sampled at the rising clock edge. No back-pressure is involved: the requests tell a DMA engine when to act, and the strobes report what it did.

Top module: `fbr_inbuf_req`

## Requirements
- R1: While `rst` is high at a rising edge, `feed_req`, `mon_req` and `ovr_flag` are 0 after that edge, and the buffer is empty.
- R2: `feed_req` can only be 1 after an edge where `src_sel`=0 (0 selects host feed, 1 selects converter feed) and `dma_en`=1; otherwise it is 0 after that edge.
- R3: In an active host-feed cycle, `feed_req` after the edge equals "buffer empty". A `buf_wr` fills the buffer. A `buf_take` without `buf_wr` empties it. When both are asserted, the buffer stays full.
- R4: `mon_req` can only be 1 after an edge where `src_sel`=1, `dma_en`=1 and `dbg_en`=1; otherwise it is 0 after that edge.
- R5: In an active monitor cycle, `smp_ld` sets `mon_req` at the edge. Without `smp_ld`, `buf_rd` clears it. With neither strobe, it holds.
- R6: When `smp_ld` arrives in an active monitor cycle while `mon_req` is already 1, `ovr_flag` is set at that edge. This also applies when `buf_rd` is high in the same cycle. `mon_req` stays 1 for the new sample.
- R7: `ovr_flag` is sticky: it holds until an `ovr_clr` strobe clears it at the next edge.
- R8: If the overrun set condition of R6 and `ovr_clr` occur in the same cycle, `ovr_flag` is 1 after the edge.
- R9: `soft_rst` has priority over every other input. After the edge it leaves `feed_req`, `mon_req` and `ovr_flag` at 0 and the buffer empty.
- R10: `ovr_irq` equals `ovr_flag` AND `ovr_ie` at all times, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| soft_rst | input | 1 | Soft reset strobe |
| src_sel | input | 1 | Input source: 0 host feed, 1 converter |
| dma_en | input | 1 | DMA enable |
| dbg_en | input | 1 | Debug monitor enable |
| buf_wr | input | 1 | Host/DMA writes a word into the buffer |
| buf_take | input | 1 | Filter consumes the buffered word |
| smp_ld | input | 1 | Converter loads a sample into the buffer |
| buf_rd | input | 1 | DMA read of the buffer register |
| ovr_clr | input | 1 | Write-one-to-clear strobe for the overrun flag |
| ovr_ie | input | 1 | Overrun interrupt enable |
| feed_req | output | 1 | Host-feed DMA request |
| mon_req | output | 1 | Debug-monitor DMA request |
| ovr_flag | output | 1 | Sticky monitor overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
`feed_req`, `mon_req` and `ovr_flag` are registered. Each reflects a strobe or mode change one rising edge after that strobe or change is applied, while `ovr_irq` follows `ovr_ie` in the same cycle. The bench drives every input on a falling edge. It advances a requirement-derived model across the following rising edge and compares all four outputs at the next falling edge, so every check looks at exactly one edge's worth of consequence. The sweep cycles through all eight combinations of the mode inputs and applies pseudo-random strobe patterns within each, including rare soft resets. Directed sequences pin down the set-beats-clear and read-with-load overrun corners.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic {
    SRC_HOST = 1'b0,
    SRC_CONV = 1'b1
  } src_e;
endpackage

// File: rtl/fbr_feed_req.sv
module fbr_feed_req (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic active,
  input  logic wr,
  input  logic take,
  output logic req
);
  logic full_q;
  logic full_d;

  // write beats take: the word written this cycle is what the buffer holds
  always_comb begin
    if (wr)        full_d = 1'b1;
    else if (take) full_d = 1'b0;
    else           full_d = full_q;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      full_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      full_q <= full_d;
      req    <= active && !full_d;
    end
  end

  // R3: a write leaves the buffer occupied, so the request is down
  a_r3_wr_drops: assert property (@(posedge clk) disable iff (rst)
    (wr && !soft_rst) |=> !req);
  // R2: outside host-feed DMA mode the request stays low
  a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
    !active |=> !req);
endmodule

// File: rtl/fbr_mon_req.sv
module fbr_mon_req (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic active,
  input  logic ld,
  input  logic rd,
  output logic req,
  output logic ovr_hit
);
  // a sample arriving on a still-pending request is an overrun
  assign ovr_hit = active && ld && req;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) req <= 1'b0;
    else if (!active)    req <= 1'b0;
    else if (ld)         req <= 1'b1;
    else if (rd)         req <= 1'b0;
  end

  // R4: no monitor request unless converter, DMA and debug are all on
  a_r4_inactive_low: assert property (@(posedge clk) disable iff (rst)
    !active |=> !req);
  // R5: a sample load raises the request
  a_r5_load_sets: assert property (@(posedge clk) disable iff (rst)
    (active && ld && !soft_rst) |=> req);
  // R5: without a read the request is held
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (req && active && !rd && !soft_rst) |=> req);
endmodule

// File: rtl/fbr_ovr_flag.sv
module fbr_ovr_flag (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) flag <= 1'b0;
    else if (set)        flag <= 1'b1;
    else if (clr)        flag <= 1'b0;
  end

  assign irq = flag && ie;

  // R8: a set in the same cycle as a clear leaves the flag up
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set && !soft_rst) |=> flag);
  // R7: sticky until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr && !soft_rst) |=> flag);
  // R7: a lone clear takes effect at the next edge
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/fbr_inbuf_req.sv
module fbr_inbuf_req
  import fbr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic src_sel,
  input  logic dma_en,
  input  logic dbg_en,
  input  logic buf_wr,
  input  logic buf_take,
  input  logic smp_ld,
  input  logic buf_rd,
  input  logic ovr_clr,
  input  logic ovr_ie,
  output logic feed_req,
  output logic mon_req,
  output logic ovr_flag,
  output logic ovr_irq
);
  src_e src;
  logic feed_act;
  logic mon_act;
  logic ovr_hit;

  assign src      = src_e'(src_sel);
  assign feed_act = (src == SRC_HOST) && dma_en;
  assign mon_act  = (src == SRC_CONV) && dma_en && dbg_en;

  fbr_feed_req u_feed (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .active   (feed_act),
    .wr       (buf_wr),
    .take     (buf_take),
    .req      (feed_req)
  );

  fbr_mon_req u_mon (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .active   (mon_act),
    .ld       (smp_ld),
    .rd       (buf_rd),
    .req      (mon_req),
    .ovr_hit  (ovr_hit)
  );

  fbr_ovr_flag u_ovr (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .set      (ovr_hit),
    .clr      (ovr_clr),
    .ie       (ovr_ie),
    .flag     (ovr_flag),
    .irq      (ovr_irq)
  );

  // R1: hard reset idles every status output
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!feed_req && !mon_req && !ovr_flag));
  // R9: soft reset idles both requests and the flag
  a_r9_soft: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!feed_req && !mon_req && !ovr_flag));
  // R6: a load on a pending monitor request, even alongside a read, flags overrun
  a_r6_overrun: assert property (@(posedge clk) disable iff (rst)
    (mon_act && smp_ld && mon_req && !soft_rst) |=> (ovr_flag && mon_req));
endmodule

// File: tb/tb_fbr_inbuf_req.sv
module tb_fbr_inbuf_req;
  localparam int CLK_P = 10;
  localparam int SWEEP = 4096;

  logic clk = 1'b0;
  logic rst, soft_rst, src_sel, dma_en, dbg_en;
  logic buf_wr, buf_take, smp_ld, buf_rd, ovr_clr, ovr_ie;
  logic feed_req, mon_req, ovr_flag, ovr_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // requirement model state
  bit e_full, e_feed, e_mon, e_ovr;
  bit l_srst, l_rst, l_feed_act, l_mon_act, l_set, l_clr;

  always #(CLK_P/2) clk = ~clk;

  fbr_inbuf_req dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .src_sel(src_sel),
    .dma_en(dma_en), .dbg_en(dbg_en), .buf_wr(buf_wr), .buf_take(buf_take),
    .smp_ld(smp_ld), .buf_rd(buf_rd), .ovr_clr(ovr_clr), .ovr_ie(ovr_ie),
    .feed_req(feed_req), .mon_req(mon_req), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
  );

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // advance model for one rising edge with the inputs now applied
  task automatic model_edge();
    bit fa, ma, nfull, set;
    fa  = !src_sel && dma_en;
    ma  = src_sel && dma_en && dbg_en;
    set = ma && smp_ld && e_mon;
    l_rst = rst; l_srst = soft_rst; l_feed_act = fa; l_mon_act = ma;
    l_set = set; l_clr = ovr_clr;
    if (rst || soft_rst) begin
      e_full = 0; e_feed = 0; e_mon = 0; e_ovr = 0;
    end else begin
      nfull = buf_wr ? 1'b1 : (buf_take ? 1'b0 : e_full);
      e_full = nfull;
      e_feed = fa && !nfull;
      if (!ma) e_mon = 0;
      else if (smp_ld) e_mon = 1;
      else if (buf_rd) e_mon = 0;
      e_ovr = set ? 1'b1 : (ovr_clr ? 1'b0 : e_ovr);
    end
  endtask

  task automatic compare();
    string tf, tm, to;
    tf = l_rst ? "R1" : l_srst ? "R9" : !l_feed_act ? "R2" : "R3";
    tm = l_rst ? "R1" : l_srst ? "R9" : !l_mon_act ? "R4" : l_set ? "R6" : "R5";
    to = l_rst ? "R1" : l_srst ? "R9" : (l_set && l_clr) ? "R8" : l_set ? "R6" : "R7";
    chk(tf, "feed_req", feed_req, e_feed);
    chk(tm, "mon_req", mon_req, e_mon);
    chk(to, "ovr_flag", ovr_flag, e_ovr);
    chk("R10", "ovr_irq", ovr_irq, e_ovr && ovr_ie);
  endtask

  // apply inputs at a falling edge, pass one rising edge, compare at next falling edge
  task automatic step(input bit sr, input bit s, input bit d, input bit g,
                      input bit w, input bit tk, input bit l, input bit r,
                      input bit c, input bit ie);
    soft_rst = sr; src_sel = s; dma_en = d; dbg_en = g;
    buf_wr = w; buf_take = tk; smp_ld = l; buf_rd = r; ovr_clr = c; ovr_ie = ie;
    model_edge();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf;
    rst = 1; soft_rst = 0; src_sel = 0; dma_en = 1; dbg_en = 1;
    buf_wr = 0; buf_take = 0; smp_ld = 0; buf_rd = 0; ovr_clr = 0; ovr_ie = 1;
    model_edge();
    repeat (3) @(negedge clk);
    compare(); // R1 reset state
    rst = 0;

    // R3 host feed: empty buffer requests, write drops, take re-raises
    step(0,0,1,0, 0,0,0,0,0,1);
    chk("R3", "feed_req empty", feed_req, 1'b1);
    step(0,0,1,0, 1,0,0,0,0,1);
    chk("R3", "feed_req after write", feed_req, 1'b0);
    step(0,0,1,0, 1,1,0,0,0,1);
    step(0,0,1,0, 0,1,0,0,0,1);
    chk("R3", "feed_req after take", feed_req, 1'b1);

    // R6 / R8 monitor overrun with read in same cycle, then set beats clear
    step(0,1,1,1, 0,0,1,0,0,1);
    chk("R5", "mon_req after load", mon_req, 1'b1);
    step(0,1,1,1, 0,0,1,1,0,1);
    chk("R6", "ovr_flag load+read", ovr_flag, 1'b1);
    step(0,1,1,1, 0,0,1,0,1,1);
    chk("R8", "ovr_flag set vs clear", ovr_flag, 1'b1);
    step(0,1,1,1, 0,0,0,1,1,0);
    chk("R7", "ovr_flag cleared", ovr_flag, 1'b0);
    chk("R5", "mon_req after read", mon_req, 1'b0);

    // R9 soft reset from a busy state
    step(0,1,1,1, 0,0,1,0,0,1);
    step(0,1,1,1, 0,0,1,0,0,1);
    step(1,1,1,1, 0,0,1,0,0,1);
    chk("R9", "mon_req soft", mon_req, 1'b0);
    chk("R9", "ovr_flag soft", ovr_flag, 1'b0);

    // sweep all eight mode combinations with pseudo-random strobes
    lf = 32'hACE1_2B35;
    for (int i = 0; i < SWEEP; i++) begin
      bit [2:0] m;
      m  = 3'((i / 64) % 8);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[15:10] == 6'd0, m[0], m[1], m[2],
           lf[0], lf[1], lf[2], lf[3] & lf[4], lf[7:5] == 3'd0, lf[8]);
    end

    // R1 hard reset from whatever state the sweep left
    rst = 1;
    step(0,1,1,1, 0,0,1,0,0,1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule